// File: doc/BRIEF.md
# Job Descriptor Launch Sequencer

This block starts and retires one accelerator job at a time. Host software places a one-cache-line job descriptor in shared memory and hands its address to the accelerator, together with an attach event. The block then fetches that line with a single read request and splits it into typed fields. It hands those fields to the compute unit with a one-cycle start pulse.

Once the compute unit raises its done flag, the block posts a one-byte write of 0x01 to the descriptor's base address. Host software spins on that byte, which it cleared before attaching, so the completion report is a single zero-to-nonzero transition per job. No register handshake is involved. The block accepts a new attach only after the status write has been acknowledged.

Top module: `job_launch_seq`

## Requirements
- R1: While rst_ni is low, both request valids and cu_start_o are 0 and every record field output is 0. After reset the block is idle and accepts an attach.
- R2: An attach_i seen while idle latches wed_addr_i. From the next cycle rd_req_valid_o is 1 with rd_req_addr_o equal to the latched address. Both stay unchanged until a cycle with rd_req_ready_i high.
- R3: Each job issues exactly one read request handshake. rd_req_valid_o is 0 in the cycle after the handshake.
- R4: The returned 1024-bit line decodes as follows: cu_head_o = bits 31:0 (status byte in 7:0), cu_size_o = bits 63:32, cu_src_o = bits 127:64, cu_dst_o = bits 191:128, cu_args_o = bits 1023:192.
- R5: The cycle after rd_data_valid_i is seen while waiting for the line, cu_start_o is 1 for exactly one cycle, and the decoded fields are valid in that same cycle. The fields stay unchanged until the next job loads.
- R6: wr_req_valid_o rises only in the cycle after cu_done_i is seen after the start pulse. It carries address = descriptor base and data = 8'h01. Valid, address and data are held until wr_req_ready_i.
- R7: Each job issues exactly one status write handshake. wr_req_valid_o is 0 in the cycle after the handshake.
- R8: The block stays busy until wr_ack_i. An attach before the ack, or in the single cycle after it, produces no read request. An attach after that starts a new job.
- R9: attach_i while a job is in progress has no effect on the read request address or on the job.
- R10: rd_data_valid_i outside the wait-for-line phase leaves the record unchanged. cu_done_i outside the run phase produces no status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| attach_i | input | 1 | Job launch event |
| wed_addr_i | input | 64 | Descriptor base address, sampled with attach_i |
| rd_req_valid_o | output | 1 | Descriptor line read request |
| rd_req_addr_o | output | 64 | Read address |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_data_valid_i | input | 1 | Returned line valid |
| rd_data_i | input | 1024 | Returned descriptor line |
| cu_start_o | output | 1 | One-cycle compute unit start |
| cu_head_o | output | 32 | Descriptor bits 31:0 |
| cu_size_o | output | 32 | Job size in cache lines |
| cu_src_o | output | 64 | Source address |
| cu_dst_o | output | 64 | Destination address |
| cu_args_o | output | 832 | Spare argument words, bits 1023:192 |
| cu_done_i | input | 1 | Compute unit finished |
| wr_req_valid_o | output | 1 | Status byte write request |
| wr_req_addr_o | output | 64 | Status write address |
| wr_req_data_o | output | 8 | Status byte value |
| wr_req_ready_i | input | 1 | Write request accepted |
| wr_ack_i | input | 1 | Status write completed |

## Verification
The bench sweeps jobs with varying read-ready, line-return, run-length and write-ready delays. It checks every field against bit slices of a computed line.

It targets the following corner cases:
- A held request whose address would change under back-pressure.
- A second read or second status write per job, which would double-report completion to the host.
- A stray done flag while the line is still in flight, which a careless design would turn into an early status write.
- A stray returned line during the run, which would corrupt the record under the compute unit.
- Attach events during the fetch, the ack wait and the final cycle, which a design that leaves idle too early would turn into a spurious read.

A mid-job reset confirms that the record and all valids clear.

// File: rtl/job_launch_pkg.sv
package job_launch_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned LINE_W = 1024;
  localparam int unsigned HEAD_W = 32;
  localparam int unsigned SIZE_W = 32;
  localparam int unsigned ARG_LSB = HEAD_W + SIZE_W + 2 * ADDR_W;
  localparam int unsigned ARG_W = LINE_W - ARG_LSB;
  localparam int unsigned STAT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_DATA, ST_RUN, ST_WR_STATUS, ST_WAIT_ACK, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [ARG_W-1:0]  args;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [SIZE_W-1:0] size;
    logic [HEAD_W-1:0] head;
  } job_rec_t;
endpackage

// File: rtl/job_desc_decode.sv
module job_desc_decode
  import job_launch_pkg::*;
(
  input  logic [LINE_W-1:0] line_i,
  output job_rec_t          rec_o
);
  localparam int unsigned SIZE_LSB = HEAD_W;
  localparam int unsigned SRC_LSB  = SIZE_LSB + SIZE_W;
  localparam int unsigned DST_LSB  = SRC_LSB + ADDR_W;

  always_comb begin
    rec_o.head = line_i[HEAD_W-1:0];
    rec_o.size = line_i[SIZE_LSB +: SIZE_W];
    rec_o.src  = line_i[SRC_LSB +: ADDR_W];
    rec_o.dst  = line_i[DST_LSB +: ADDR_W];
    rec_o.args = line_i[ARG_LSB +: ARG_W];
  end
endmodule

// File: rtl/job_record_reg.sv
module job_record_reg
  import job_launch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  job_rec_t rec_i,
  output job_rec_t rec_o
);
  job_rec_t rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rec_q <= '0;
    else if (load_i) rec_q <= rec_i;
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/job_launch_fsm.sv
module job_launch_fsm
  import job_launch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              attach_i,
  input  logic [ADDR_W-1:0] wed_addr_i,
  input  logic              rd_req_ready_i,
  input  logic              rd_data_valid_i,
  input  logic              cu_done_i,
  input  logic              wr_req_ready_i,
  input  logic              wr_ack_i,
  output logic              rd_req_valid_o,
  output logic              wr_req_valid_o,
  output logic              rec_load_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] base_addr_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              start_q;

  assign rec_load_o = (state_q == ST_WAIT_DATA) && rd_data_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (attach_i)       state_d = ST_FETCH;
      ST_FETCH:     if (rd_req_ready_i) state_d = ST_WAIT_DATA;
      ST_WAIT_DATA: if (rd_data_valid_i) state_d = ST_RUN;
      // done is only honoured once the start pulse has been seen
      ST_RUN:       if (cu_done_i && !start_q) state_d = ST_WR_STATUS;
      ST_WR_STATUS: if (wr_req_ready_i) state_d = ST_WAIT_ACK;
      ST_WAIT_ACK:  if (wr_ack_i)       state_d = ST_DONE;
      ST_DONE:                          state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= rec_load_o;
      if (state_q == ST_IDLE && attach_i) base_q <= wed_addr_i;
    end
  end

  assign rd_req_valid_o = (state_q == ST_FETCH);
  assign wr_req_valid_o = (state_q == ST_WR_STATUS);
  assign start_o        = start_q;
  assign base_addr_o    = base_q;
endmodule

// File: rtl/job_launch_seq.sv
module job_launch_seq
  import job_launch_pkg::*;
#(
  parameter logic [STAT_W-1:0] STATUS_CODE = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              attach_i,
  input  logic [ADDR_W-1:0] wed_addr_i,
  output logic              rd_req_valid_o,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_req_ready_i,
  input  logic              rd_data_valid_i,
  input  logic [LINE_W-1:0] rd_data_i,
  output logic              cu_start_o,
  output logic [HEAD_W-1:0] cu_head_o,
  output logic [SIZE_W-1:0] cu_size_o,
  output logic [ADDR_W-1:0] cu_src_o,
  output logic [ADDR_W-1:0] cu_dst_o,
  output logic [ARG_W-1:0]  cu_args_o,
  input  logic              cu_done_i,
  output logic              wr_req_valid_o,
  output logic [ADDR_W-1:0] wr_req_addr_o,
  output logic [STAT_W-1:0] wr_req_data_o,
  input  logic              wr_req_ready_i,
  input  logic              wr_ack_i
);
  job_rec_t          rec_dec, rec_cur;
  logic              rec_load;
  logic [ADDR_W-1:0] base_addr;

  job_launch_fsm u_fsm (
    .clk_i, .rst_ni, .attach_i, .wed_addr_i, .rd_req_ready_i, .rd_data_valid_i,
    .cu_done_i, .wr_req_ready_i, .wr_ack_i, .rd_req_valid_o, .wr_req_valid_o,
    .rec_load_o (rec_load),
    .start_o    (cu_start_o),
    .base_addr_o(base_addr)
  );

  job_desc_decode u_dec (.line_i(rd_data_i), .rec_o(rec_dec));

  job_record_reg u_rec (
    .clk_i, .rst_ni, .load_i(rec_load), .rec_i(rec_dec), .rec_o(rec_cur)
  );

  assign rd_req_addr_o = base_addr;
  assign wr_req_addr_o = base_addr;
  assign wr_req_data_o = STATUS_CODE;
  assign cu_head_o     = rec_cur.head;
  assign cu_size_o     = rec_cur.size;
  assign cu_src_o      = rec_cur.src;
  assign cu_dst_o      = rec_cur.dst;
  assign cu_args_o     = rec_cur.args;
endmodule

// File: rtl/job_launch_chk.sv
module job_launch_chk
  import job_launch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_valid_o,
  input logic [ADDR_W-1:0] rd_req_addr_o,
  input logic              rd_req_ready_i,
  input logic              cu_start_o,
  input logic [SIZE_W-1:0] cu_size_o,
  input logic [ADDR_W-1:0] cu_src_o,
  input logic [ADDR_W-1:0] cu_dst_o,
  input logic              cu_done_i,
  input logic              wr_req_valid_o,
  input logic [ADDR_W-1:0] wr_req_addr_o,
  input logic [STAT_W-1:0] wr_req_data_o,
  input logic              wr_req_ready_i
);
  logic rd_seen, wr_seen, running, done_seen;
  logic rd_hs, wr_hs;

  assign rd_hs = rd_req_valid_o && rd_req_ready_i;
  assign wr_hs = wr_req_valid_o && wr_req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_seen <= 1'b0; wr_seen <= 1'b0; running <= 1'b0; done_seen <= 1'b0;
    end else begin
      if (rd_hs) begin rd_seen <= 1'b1; wr_seen <= 1'b0; end
      if (wr_hs) begin wr_seen <= 1'b1; rd_seen <= 1'b0; end
      if (cu_start_o) running <= 1'b1;
      else if (wr_hs) running <= 1'b0;
      if (running && !cu_start_o && cu_done_i) done_seen <= 1'b1;
      else if (wr_hs) done_seen <= 1'b0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o)); // R2
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hs |-> !rd_seen); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cu_start_o |=> !cu_start_o); // R5
  AST_REC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running && !cu_start_o |-> $stable(cu_size_o) && $stable(cu_src_o) && $stable(cu_dst_o)); // R5
  AST_WR_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_req_valid_o) |-> done_seen); // R6
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_valid_o && !wr_req_ready_i |=> wr_req_valid_o && $stable(wr_req_addr_o)); // R6
  AST_WR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_valid_o |-> wr_req_data_o == 8'h01 && wr_req_addr_o == rd_req_addr_o); // R6
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hs |-> !wr_seen); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_valid_o && wr_req_valid_o)); // R8
endmodule

bind job_launch_seq job_launch_chk u_chk (
  .clk_i, .rst_ni, .rd_req_valid_o, .rd_req_addr_o, .rd_req_ready_i, .cu_start_o,
  .cu_size_o, .cu_src_o, .cu_dst_o, .cu_done_i, .wr_req_valid_o, .wr_req_addr_o,
  .wr_req_data_o, .wr_req_ready_i
);

// File: tb/job_launch_seq_bench.sv
module job_launch_seq_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic attach_i = 0, rd_req_ready_i = 0, rd_data_valid_i = 0;
  logic cu_done_i = 0, wr_req_ready_i = 0, wr_ack_i = 0;
  logic [63:0] wed_addr_i = '0;
  logic [1023:0] rd_data_i = '0;
  logic rd_req_valid_o, cu_start_o, wr_req_valid_o;
  logic [63:0] rd_req_addr_o, cu_src_o, cu_dst_o, wr_req_addr_o;
  logic [31:0] cu_head_o, cu_size_o;
  logic [831:0] cu_args_o;
  logic [7:0] wr_req_data_o;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  job_launch_seq u_job_launch_seq (.clk_i(clk), .*);

  task automatic chk(string tag, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1023:0] make_line(int j);
    logic [1023:0] l;
    for (int w = 0; w < 16; w++)
      l[w*64 +: 64] = {32'(j * 32'h0101_0007 + w * 13 + 1), 32'(w * 32'h0011_0003 ^ j)};
    return l;
  endfunction

  task automatic check_record(string tag, logic [1023:0] l);
    chk({tag, " head"}, 1024'(cu_head_o), 1024'(l[31:0]));
    chk({tag, " size"}, 1024'(cu_size_o), 1024'(l[63:32]));
    chk({tag, " src"},  1024'(cu_src_o),  1024'(l[127:64]));
    chk({tag, " dst"},  1024'(cu_dst_o),  1024'(l[191:128]));
    chk({tag, " args"}, 1024'(cu_args_o), 1024'(l[1023:192]));
  endtask

  task automatic run_job(int j);
    logic [63:0] base = 64'h0000_1000_0000_0000 + 64'(j) * 64'h80;
    logic [1023:0] line = make_line(j);
    int rd_dly = j % 4, wr_dly = (j / 4) % 4, data_dly = 1 + j % 3, run_len = 1 + j % 5;
    chk("R8 idle no rd", 1024'(rd_req_valid_o), 0);
    attach_i = 1; wed_addr_i = base;
    @(negedge clk); attach_i = 0;
    chk("R2 rd valid", 1024'(rd_req_valid_o), 1);
    chk("R2 rd addr", 1024'(rd_req_addr_o), 1024'(base));
    if (j % 2 == 1) begin attach_i = 1; wed_addr_i = ~base; end  // R9 stray attach
    for (int k = 0; k < rd_dly; k++) begin
      @(negedge clk); attach_i = 0;
      chk("R2 rd hold", 1024'(rd_req_valid_o), 1);
      chk("R9 rd addr kept", 1024'(rd_req_addr_o), 1024'(base));
    end
    rd_req_ready_i = 1;
    @(negedge clk); rd_req_ready_i = 0; attach_i = 0;
    chk("R3 rd dropped", 1024'(rd_req_valid_o), 0);
    for (int k = 0; k < data_dly; k++) begin
      cu_done_i = (j % 2 == 1) && (k == 0);  // R10 stray done
      @(negedge clk); cu_done_i = 0;
      chk("R10 no early wr", 1024'(wr_req_valid_o), 0);
      chk("R5 no early start", 1024'(cu_start_o), 0);
    end
    rd_data_valid_i = 1; rd_data_i = line;
    @(negedge clk); rd_data_valid_i = 0;
    chk("R5 start", 1024'(cu_start_o), 1);
    check_record("R4 R5", line);
    if (j % 2 == 1) begin rd_data_valid_i = 1; rd_data_i = ~line; end
    @(negedge clk); rd_data_valid_i = 0;
    chk("R5 start single", 1024'(cu_start_o), 0);
    check_record("R10 rec kept", line);
    for (int k = 0; k < run_len; k++) begin
      @(negedge clk);
      chk("R6 wr waits done", 1024'(wr_req_valid_o), 0);
    end
    cu_done_i = 1;
    @(negedge clk); cu_done_i = 0;
    chk("R6 wr valid", 1024'(wr_req_valid_o), 1);
    chk("R6 wr addr", 1024'(wr_req_addr_o), 1024'(base));
    chk("R6 wr data", 1024'(wr_req_data_o), 1024'(8'h01));
    for (int k = 0; k < wr_dly; k++) begin
      @(negedge clk);
      chk("R6 wr hold", 1024'(wr_req_valid_o), 1);
      chk("R6 wr addr hold", 1024'(wr_req_addr_o), 1024'(base));
    end
    wr_req_ready_i = 1;
    @(negedge clk); wr_req_ready_i = 0;
    chk("R7 wr dropped", 1024'(wr_req_valid_o), 0);
    attach_i = 1;  // R8 attach during ack wait
    @(negedge clk); attach_i = 0;
    chk("R8 busy until ack", 1024'(rd_req_valid_o), 0);
    chk("R7 no second wr", 1024'(wr_req_valid_o), 0);
    wr_ack_i = 1;
    @(negedge clk); wr_ack_i = 0;
    attach_i = 1;  // R8 attach in final cycle
    @(negedge clk); attach_i = 0;
    chk("R8 final cycle ignores attach", 1024'(rd_req_valid_o), 0);
    chk("R5 rec held to next job", 1024'(cu_size_o), 1024'(line[63:32]));
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 reset rd", 1024'(rd_req_valid_o), 0);
    chk("R1 reset wr", 1024'(wr_req_valid_o), 0);
    chk("R1 reset start", 1024'(cu_start_o), 0);
    check_record("R1 reset rec", '0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    for (int j = 0; j < 32; j++) run_job(j);
    // R1 mid-job reset
    attach_i = 1; wed_addr_i = 64'hABC0;
    @(negedge clk); attach_i = 0; rd_req_ready_i = 1;
    @(negedge clk); rd_req_ready_i = 0; rd_data_valid_i = 1; rd_data_i = make_line(99);
    @(negedge clk); rd_data_valid_i = 0;
    chk("R1 pre-reset start", 1024'(cu_start_o), 1);
    rst_ni = 0;
    #1;
    chk("R1 reset start clr", 1024'(cu_start_o), 0);
    check_record("R1 reset rec clr", '0);
    chk("R1 reset rd clr", 1024'(rd_req_valid_o), 0);
    @(negedge clk); rst_ni = 1;
    cu_done_i = 1;
    @(negedge clk); cu_done_i = 0;
    chk("R1 idle after reset no wr", 1024'(wr_req_valid_o), 0);
    attach_i = 1; wed_addr_i = 64'h5500;
    @(negedge clk); attach_i = 0;
    chk("R1 attach after reset", 1024'(rd_req_valid_o), 1);
    chk("R1 attach addr", 1024'(rd_req_addr_o), 1024'(64'h5500));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule